// File: doc/BRIEF.md
# Early Branch Resolution Controller

This block is the control heart of the fetch and decode front end of a five-stage in-order pipeline. Conditional branches are settled in the decode stage, one stage earlier than execute. The block compares the two source operands of the decoding branch for equality and computes the branch and jump targets there. It then drives the PC-select mux, the PC write enable, the IF/ID write enable, the IF/ID flush-to-nop line and a bubble request into ID/EX.

The comparator cannot always use the register-file values. An operand still being produced by the instruction in execute stalls the branch. A load result sitting in the memory stage also stalls it. An ALU result sitting in the memory stage is forwarded into the comparator.

A static mode input picks one of two ways to treat the instruction fetched behind a branch. In delay-slot mode that instruction always executes. In predict-not-taken mode it is squashed when the branch or jump redirects fetch. The block is purely combinational apart from the clocked checks it carries.

Top module: `branch_resolve_ctrl`

## Requirements
- R1: A taken conditional branch drives `redirect_pc` = `id_pc_plus4` + (sign-extended `id_offset` × 4), with 32-bit wrap-around.
- R2: `pc_sel` encodes 0 = sequential, 1 = branch target, 2 = jump target. A BEQ is taken when its two operands are equal and a BNE when they differ. When a branch is not taken, `pc_sel` is 0.
- R3: A jump selects `pc_sel` = 2 with `redirect_pc` = {`id_pc_plus4`[31:28], `id_jump_index`, 2'b00}, and register hazards never stall it.
- R4: With `mode_delay_slot` = 1, `ifid_flush` is never asserted, so the instruction behind a taken branch or jump is kept.
- R5: With `mode_delay_slot` = 0, a taken branch or a jump asserts `ifid_flush` in its resolving cycle. A branch that is not taken leaves `ifid_flush` low and costs no cycle.
- R6: When a branch operand register (not r0) equals `ex_rd` while `ex_wr_en` is 1, the block stalls. A stall means `pc_we` = 0, `ifid_we` = 0, `idex_bubble` = 1, `pc_sel` = 0 and `ifid_flush` = 0. A stall takes priority over any redirect.
- R7: A load writing a branch operand stalls the branch for both cycles it spends in execute and in memory (`mem_is_load` = 1 with `mem_rd` matching). The branch resolves in the cycle after that.
- R8: When a branch operand matches `mem_rd` of a non-load writer in memory and nothing in execute matches it, `mem_result` replaces the register-file value in the comparison.
- R9: Register index 0 never causes a stall or a forward; its register-file value is used.
- R10: When no branch or jump is in decode (including out of reset), the outputs are `pc_we` = 1, `ifid_we` = 1, `pc_sel` = 0, `ifid_flush` = 0 and `idex_bubble` = 0, whatever hazards are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the built-in checks) |
| rst_n | input | 1 | Synchronous active-low reset for the checks |
| mode_delay_slot | input | 1 | 1 = delay-slot mode, 0 = predict-not-taken mode |
| id_is_beq | input | 1 | Decode holds a branch-if-equal |
| id_is_bne | input | 1 | Decode holds a branch-if-not-equal |
| id_is_jump | input | 1 | Decode holds an absolute jump |
| id_pc_plus4 | input | 32 | Address after the decoding instruction |
| id_offset | input | 16 | Word offset field of the branch |
| id_jump_index | input | 26 | Word index field of the jump |
| id_rs | input | 5 | First source register index |
| id_rt | input | 5 | Second source register index |
| id_rs_val | input | 32 | Register-file value of the first source |
| id_rt_val | input | 32 | Register-file value of the second source |
| ex_wr_en | input | 1 | Instruction in execute writes a register (ALU or load) |
| ex_rd | input | 5 | Destination register of the instruction in execute |
| mem_wr_en | input | 1 | Instruction in memory writes a register |
| mem_is_load | input | 1 | Instruction in memory is a load |
| mem_rd | input | 5 | Destination register of the instruction in memory |
| mem_result | input | 32 | ALU result held in the EX/MEM register |
| pc_sel | output | 2 | PC mux select: 0 sequential, 1 branch, 2 jump |
| redirect_pc | output | 32 | Target address of the selected redirect |
| pc_we | output | 1 | PC update enable |
| ifid_we | output | 1 | IF/ID register write enable |
| ifid_flush | output | 1 | Turn the IF/ID contents into a nop |
| idex_bubble | output | 1 | Insert a nop into ID/EX while decode is held |

## Verification
Equal and unequal operand pairs are applied to both BEQ and BNE, so a swapped or inverted comparator shows up. Each case is run in both modes, which separates the flush rule from the redirect rule. Hazard patterns place the producer in execute, in memory as an ALU result, or in memory as a load, on either source and on r0. These patterns separate stalling from forwarding, and a forward that matches on the wrong stage or register changes the branch outcome. A directed load walk through execute, memory and writeback confirms the two-cycle stall length. Offsets at both ends of the signed range and a jump with a live hazard finish the set.

// File: rtl/brc_pkg.sv
// brc_pkg: shared encodings for the early branch resolution controller.
// Assumes a single PC mux with three inputs in the fetch stage.
package brc_pkg;

    // PC mux select values, decoded by the fetch stage.
    typedef enum logic [1:0] {
        PCSEL_SEQ    = 2'd0,
        PCSEL_BRANCH = 2'd1,
        PCSEL_JUMP   = 2'd2
    } pcsel_e;

    // Where a decode-stage comparator operand comes from.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_FWD_MEM = 2'd1,
        SRC_WAIT    = 2'd2
    } opnd_src_e;

endpackage

// File: rtl/brc_fwd_unit.sv
// brc_fwd_unit: picks the value of one comparator operand.
// A writer in execute makes the operand wait; this covers ALU and load alike.
// A load in memory also makes it wait. An ALU result in memory is forwarded.
// Register 0 is hard-wired to zero and never tracked.
// Assumes the register file writes before it reads, so writeback needs no bypass.
module brc_fwd_unit #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              use_op,
    input  logic [RIDX_W-1:0] idx,
    input  logic [XLEN-1:0]   rf_val,
    input  logic              ex_wr,
    input  logic [RIDX_W-1:0] ex_rd,
    input  logic              mem_wr,
    input  logic              mem_ld,
    input  logic [RIDX_W-1:0] mem_rd,
    input  logic [XLEN-1:0]   mem_val,
    output logic [XLEN-1:0]   op_val,
    output logic              op_wait
);
    import brc_pkg::*;

    localparam logic [RIDX_W-1:0] ZERO_REG = '0;

    opnd_src_e src;

    // Source choice: the younger producer in execute wins over memory.
    always_comb begin
        src = SRC_REGFILE;
        if (use_op && idx != ZERO_REG) begin
            if (ex_wr && ex_rd == idx) begin
                src = SRC_WAIT;
            end else if (mem_wr && mem_rd == idx) begin
                src = mem_ld ? SRC_WAIT : SRC_FWD_MEM;
            end
        end
    end

    // Operand value and wait flag driven from the chosen source.
    assign op_val  = (src == SRC_FWD_MEM) ? mem_val : rf_val;
    assign op_wait = (src == SRC_WAIT);

    AST_R0_UNTRACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == ZERO_REG) |-> (!op_wait && op_val == rf_val)); // R9

    AST_MEM_ALU_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (use_op && idx != ZERO_REG && !(ex_wr && ex_rd == idx) && mem_wr && !mem_ld
         && mem_rd == idx) |-> (!op_wait && op_val == mem_val)); // R8

    AST_MEM_LOAD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (use_op && idx != ZERO_REG && mem_wr && mem_ld && mem_rd == idx) |-> op_wait); // R7

endmodule

// File: rtl/brc_cond_eval.sv
// brc_cond_eval: decode-stage equality comparator and target adders.
// Branch offsets count words and are signed. The jump keeps the top PC bits.
module brc_cond_eval #(
    parameter int XLEN   = 32,
    parameter int OFF_W  = 16,
    parameter int JIDX_W = 26
) (
    input  logic [XLEN-1:0]   pc_plus4,
    input  logic [OFF_W-1:0]  offset,
    input  logic [JIDX_W-1:0] jidx,
    input  logic [XLEN-1:0]   op_a,
    input  logic [XLEN-1:0]   op_b,
    output logic              ops_equal,
    output logic [XLEN-1:0]   br_target,
    output logic [XLEN-1:0]   j_target
);
    localparam int WORD_SH = 2;
    localparam int SEXT_W  = XLEN - OFF_W - WORD_SH;
    localparam int HI_W    = XLEN - JIDX_W - WORD_SH;

    logic [XLEN-1:0] byte_off;

    // Scale the signed word offset to a byte displacement.
    assign byte_off = {{SEXT_W{offset[OFF_W-1]}}, offset, {WORD_SH{1'b0}}};

    // Comparator and both candidate targets.
    assign ops_equal = (op_a == op_b);
    assign br_target = pc_plus4 + byte_off;
    assign j_target  = {pc_plus4[XLEN-1 -: HI_W], jidx, {WORD_SH{1'b0}}};

endmodule

// File: rtl/brc_ctrl.sv
// brc_ctrl: turns the decode-stage outcome into front-end control.
// A stall outranks a redirect. A redirect and a flush appear only in the
// resolving cycle. Delay-slot mode never flushes. Assumes at most one of the
// three opcode flags is set.
module brc_ctrl #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_ds,
    input  logic            is_beq,
    input  logic            is_bne,
    input  logic            is_jump,
    input  logic            ops_equal,
    input  logic            wait_any,
    input  logic [XLEN-1:0] br_target,
    input  logic [XLEN-1:0] j_target,
    output logic [1:0]      pc_sel,
    output logic [XLEN-1:0] redirect_pc,
    output logic            pc_we,
    output logic            ifid_we,
    output logic            ifid_flush,
    output logic            idex_bubble
);
    import brc_pkg::*;

    logic   is_cond;
    logic   hold;
    logic   cond_taken;
    pcsel_e sel;

    // Classify the decoding instruction and decide whether it must wait.
    assign is_cond    = is_beq | is_bne;
    assign hold       = is_cond & wait_any;
    assign cond_taken = (is_beq & ops_equal) | (is_bne & ~ops_equal);

    // PC mux choice with stall priority over any redirect.
    always_comb begin
        sel = PCSEL_SEQ;
        if (!hold) begin
            if (is_jump && !is_cond) begin
                sel = PCSEL_JUMP;
            end else if (is_cond && cond_taken) begin
                sel = PCSEL_BRANCH;
            end
        end
    end

    // Drive the front-end controls from the choice.
    assign pc_sel      = sel;
    assign redirect_pc = (sel == PCSEL_JUMP) ? j_target : br_target;
    assign pc_we       = ~hold;
    assign ifid_we     = ~hold;
    assign ifid_flush  = (sel != PCSEL_SEQ) & ~mode_ds;
    assign idex_bubble = hold;

    AST_STALL_OUTRANKS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |-> (pc_sel == PCSEL_SEQ && !ifid_flush && !pc_we)); // R6

    AST_DS_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ds |-> !ifid_flush); // R4

    AST_PNT_SQUASHES: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ds && pc_sel != PCSEL_SEQ) |-> ifid_flush); // R5

    AST_JUMP_UNSTALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_jump && !is_cond) |-> (pc_sel == PCSEL_JUMP && pc_we)); // R3

    AST_IDLE_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_cond || is_jump) |-> (pc_we && ifid_we && pc_sel == PCSEL_SEQ
                                   && !ifid_flush && !idex_bubble)); // R10

endmodule

// File: rtl/branch_resolve_ctrl.sv
// branch_resolve_ctrl: early branch resolution controller (top).
// One forwarding unit per comparator operand (generated), the comparator and
// target logic, and the control decision. Purely combinational; clk and rst_n
// only clock the embedded checks.
module branch_resolve_ctrl #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5,
    parameter int OFF_W  = 16,
    parameter int JIDX_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_delay_slot,
    input  logic              id_is_beq,
    input  logic              id_is_bne,
    input  logic              id_is_jump,
    input  logic [XLEN-1:0]   id_pc_plus4,
    input  logic [OFF_W-1:0]  id_offset,
    input  logic [JIDX_W-1:0] id_jump_index,
    input  logic [RIDX_W-1:0] id_rs,
    input  logic [RIDX_W-1:0] id_rt,
    input  logic [XLEN-1:0]   id_rs_val,
    input  logic [XLEN-1:0]   id_rt_val,
    input  logic              ex_wr_en,
    input  logic [RIDX_W-1:0] ex_rd,
    input  logic              mem_wr_en,
    input  logic              mem_is_load,
    input  logic [RIDX_W-1:0] mem_rd,
    input  logic [XLEN-1:0]   mem_result,
    output logic [1:0]        pc_sel,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              ifid_flush,
    output logic              idex_bubble
);
    localparam int NUM_OPS = 2;

    logic [RIDX_W-1:0] op_idx [NUM_OPS];
    logic [XLEN-1:0]   op_rf  [NUM_OPS];
    logic [XLEN-1:0]   op_val [NUM_OPS];
    logic [NUM_OPS-1:0] op_wait;
    logic              uses_ops;
    logic              eq_w;
    logic [XLEN-1:0]   br_tgt_w;
    logic [XLEN-1:0]   j_tgt_w;

    // Gather the operand fields and tell whether the comparator is needed.
    assign op_idx[0] = id_rs;
    assign op_idx[1] = id_rt;
    assign op_rf[0]  = id_rs_val;
    assign op_rf[1]  = id_rt_val;
    assign uses_ops  = id_is_beq | id_is_bne;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        brc_fwd_unit #(.XLEN(XLEN), .RIDX_W(RIDX_W)) fwd_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .use_op  (uses_ops),
            .idx     (op_idx[g]),
            .rf_val  (op_rf[g]),
            .ex_wr   (ex_wr_en),
            .ex_rd   (ex_rd),
            .mem_wr  (mem_wr_en),
            .mem_ld  (mem_is_load),
            .mem_rd  (mem_rd),
            .mem_val (mem_result),
            .op_val  (op_val[g]),
            .op_wait (op_wait[g])
        );
    end

    brc_cond_eval #(.XLEN(XLEN), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) eval_i (
        .pc_plus4  (id_pc_plus4),
        .offset    (id_offset),
        .jidx      (id_jump_index),
        .op_a      (op_val[0]),
        .op_b      (op_val[1]),
        .ops_equal (eq_w),
        .br_target (br_tgt_w),
        .j_target  (j_tgt_w)
    );

    brc_ctrl #(.XLEN(XLEN)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_ds     (mode_delay_slot),
        .is_beq      (id_is_beq),
        .is_bne      (id_is_bne),
        .is_jump     (id_is_jump),
        .ops_equal   (eq_w),
        .wait_any    (|op_wait),
        .br_target   (br_tgt_w),
        .j_target    (j_tgt_w),
        .pc_sel      (pc_sel),
        .redirect_pc (redirect_pc),
        .pc_we       (pc_we),
        .ifid_we     (ifid_we),
        .ifid_flush  (ifid_flush),
        .idex_bubble (idex_bubble)
    );

    AST_EX_PRODUCER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (uses_ops && ex_wr_en && ((id_rs == ex_rd && id_rs != '0) ||
                                  (id_rt == ex_rd && id_rt != '0))) |-> idex_bubble); // R6

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == 2'd1) |-> (redirect_pc - id_pc_plus4
                              == XLEN'($signed(id_offset)) * 4)); // R1

endmodule

// File: tb/branch_resolve_ctrl_tb.sv
// Bench for branch_resolve_ctrl: a vector table walk, then directed tests.
module branch_resolve_ctrl_tb_top;

    typedef struct packed {
        logic [3:0]  req;
        logic        mode;   // 1 delay-slot, 0 predict-not-taken
        logic [1:0]  kind;   // 0 none, 1 beq, 2 bne, 3 jump
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [1:0]  ex;     // 0 none, 1 alu, 2 load
        logic [4:0]  ex_rd;
        logic [1:0]  mem;    // 0 none, 1 alu, 2 load
        logic [4:0]  mem_rd;
        logic [7:0]  mres;
        logic [15:0] imm;
        logic [1:0]  esel;
        logic        estall;
        logic        eflush;
    } vec_t;

    localparam int NV = 19;
    localparam logic [31:0] PC4  = 32'h0000_1000;
    localparam logic [25:0] JIDX = 26'h00000A0;

    localparam vec_t TBL [NV] = '{
        '{4'd2, 1'b0, 2'd1, 5'd1, 5'd2, 8'h11, 8'h11, 2'd0, 5'd0, 2'd0, 5'd0, 8'h00, 16'h0004, 2'd1, 1'b0, 1'b1},
        '{4'd2, 1'b0, 2'd1, 5'd1, 5'd2, 8'h11, 8'h12, 2'd0, 5'd0, 2'd0, 5'd0, 8'h00, 16'h0004, 2'd0, 1'b0, 1'b0},
        '{4'd4, 1'b1, 2'd2, 5'd1, 5'd2, 8'h11, 8'h12, 2'd0, 5'd0, 2'd0, 5'd0, 8'h00, 16'hFFFC, 2'd1, 1'b0, 1'b0},
        '{4'd4, 1'b1, 2'd2, 5'd1, 5'd2, 8'h33, 8'h33, 2'd0, 5'd0, 2'd0, 5'd0, 8'h00, 16'hFFFC, 2'd0, 1'b0, 1'b0},
        '{4'd3, 1'b0, 2'd3, 5'd1, 5'd2, 8'h00, 8'h01, 2'd1, 5'd1, 2'd0, 5'd0, 8'h00, 16'h0000, 2'd2, 1'b0, 1'b1},
        '{4'd3, 1'b1, 2'd3, 5'd1, 5'd2, 8'h00, 8'h01, 2'd2, 5'd2, 2'd0, 5'd0, 8'h00, 16'h0000, 2'd2, 1'b0, 1'b0},
        '{4'd6, 1'b0, 2'd1, 5'd3, 5'd4, 8'h05, 8'h05, 2'd1, 5'd3, 2'd0, 5'd0, 8'h00, 16'h0004, 2'd0, 1'b1, 1'b0},
        '{4'd6, 1'b1, 2'd2, 5'd3, 5'd4, 8'h05, 8'h06, 2'd1, 5'd4, 2'd0, 5'd0, 8'h00, 16'h0004, 2'd0, 1'b1, 1'b0},
        '{4'd7, 1'b0, 2'd1, 5'd1, 5'd2, 8'h05, 8'h05, 2'd2, 5'd1, 2'd0, 5'd0, 8'h00, 16'h0004, 2'd0, 1'b1, 1'b0},
        '{4'd7, 1'b1, 2'd1, 5'd1, 5'd2, 8'h05, 8'h05, 2'd0, 5'd0, 2'd2, 5'd2, 8'h00, 16'h0004, 2'd0, 1'b1, 1'b0},
        '{4'd8, 1'b0, 2'd1, 5'd1, 5'd2, 8'h11, 8'h22, 2'd0, 5'd0, 2'd1, 5'd1, 8'h22, 16'h0008, 2'd1, 1'b0, 1'b1},
        '{4'd8, 1'b1, 2'd2, 5'd1, 5'd2, 8'h11, 8'h55, 2'd0, 5'd0, 2'd1, 5'd2, 8'h11, 16'h0008, 2'd0, 1'b0, 1'b0},
        '{4'd9, 1'b0, 2'd1, 5'd0, 5'd2, 8'h00, 8'h00, 2'd1, 5'd0, 2'd0, 5'd0, 8'h00, 16'h0001, 2'd1, 1'b0, 1'b1},
        '{4'd9, 1'b1, 2'd1, 5'd0, 5'd2, 8'h00, 8'h00, 2'd0, 5'd0, 2'd1, 5'd0, 8'h33, 16'h0001, 2'd1, 1'b0, 1'b0},
        '{4'd10, 1'b0, 2'd0, 5'd1, 5'd2, 8'h00, 8'h00, 2'd1, 5'd1, 2'd0, 5'd0, 8'h00, 16'h0000, 2'd0, 1'b0, 1'b0},
        '{4'd10, 1'b0, 2'd0, 5'd1, 5'd1, 8'h07, 8'h07, 2'd0, 5'd0, 2'd2, 5'd1, 8'h00, 16'h0004, 2'd0, 1'b0, 1'b0},
        '{4'd6, 1'b0, 2'd1, 5'd1, 5'd2, 8'h22, 8'h22, 2'd1, 5'd1, 2'd1, 5'd1, 8'h22, 16'h0004, 2'd0, 1'b1, 1'b0},
        '{4'd1, 1'b1, 2'd1, 5'd1, 5'd2, 8'h09, 8'h09, 2'd0, 5'd0, 2'd0, 5'd0, 8'h00, 16'h8000, 2'd1, 1'b0, 1'b0},
        '{4'd1, 1'b0, 2'd2, 5'd1, 5'd2, 8'h09, 8'h0A, 2'd0, 5'd0, 2'd0, 5'd0, 8'h00, 16'h7FFF, 2'd1, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_delay_slot = 1'b0;
    logic        id_is_beq = 1'b0, id_is_bne = 1'b0, id_is_jump = 1'b0;
    logic [31:0] id_pc_plus4 = PC4;
    logic [15:0] id_offset = '0;
    logic [25:0] id_jump_index = JIDX;
    logic [4:0]  id_rs = '0, id_rt = '0;
    logic [31:0] id_rs_val = '0, id_rt_val = '0;
    logic        ex_wr_en = 1'b0;
    logic [4:0]  ex_rd = '0;
    logic        mem_wr_en = 1'b0, mem_is_load = 1'b0;
    logic [4:0]  mem_rd = '0;
    logic [31:0] mem_result = '0;
    logic [1:0]  pc_sel;
    logic [31:0] redirect_pc;
    logic        pc_we, ifid_we, ifid_flush, idex_bubble;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    branch_resolve_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mode_delay_slot(mode_delay_slot),
        .id_is_beq(id_is_beq), .id_is_bne(id_is_bne), .id_is_jump(id_is_jump),
        .id_pc_plus4(id_pc_plus4), .id_offset(id_offset), .id_jump_index(id_jump_index),
        .id_rs(id_rs), .id_rt(id_rt), .id_rs_val(id_rs_val), .id_rt_val(id_rt_val),
        .ex_wr_en(ex_wr_en), .ex_rd(ex_rd), .mem_wr_en(mem_wr_en),
        .mem_is_load(mem_is_load), .mem_rd(mem_rd), .mem_result(mem_result),
        .pc_sel(pc_sel), .redirect_pc(redirect_pc), .pc_we(pc_we), .ifid_we(ifid_we),
        .ifid_flush(ifid_flush), .idex_bubble(idex_bubble)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        mode_delay_slot = v.mode;
        id_is_beq  = (v.kind == 2'd1);
        id_is_bne  = (v.kind == 2'd2);
        id_is_jump = (v.kind == 2'd3);
        id_rs = v.rs;  id_rt = v.rt;
        id_rs_val = {24'h0, v.a};  id_rt_val = {24'h0, v.b};
        ex_wr_en = (v.ex != 2'd0);  ex_rd = v.ex_rd;
        mem_wr_en = (v.mem != 2'd0); mem_is_load = (v.mem == 2'd2); mem_rd = v.mem_rd;
        mem_result = {24'h0, v.mres};
        id_offset = v.imm;
    endtask

    task automatic check_outputs(input string req, input logic [1:0] esel,
                                 input logic estall, input logic eflush);
        logic [31:0] exp_tgt;
        chk(req, "pc_sel", {30'h0, pc_sel}, {30'h0, esel});
        chk(req, "pc_we", {31'h0, pc_we}, {31'h0, ~estall});
        chk(req, "ifid_we", {31'h0, ifid_we}, {31'h0, ~estall});
        chk(req, "idex_bubble", {31'h0, idex_bubble}, {31'h0, estall});
        chk(req, "ifid_flush", {31'h0, ifid_flush}, {31'h0, eflush});
        if (esel == 2'd1) begin
            exp_tgt = id_pc_plus4 + 32'($signed(id_offset)) * 32'd4;
            chk(req, "branch target", redirect_pc, exp_tgt);
        end else if (esel == 2'd2) begin
            exp_tgt = {id_pc_plus4[31:28], id_jump_index, 2'b00};
            chk(req, "jump target", redirect_pc, exp_tgt);
        end
    endtask

    initial begin
        // Reset state: idle decode, all outputs in the flowing state (R10).
        repeat (3) @(negedge clk);
        #2 check_outputs("R10", 2'd0, 1'b0, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // Table walk over all requirements R1 to R10.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(TBL[i]);
            #2 check_outputs($sformatf("R%0d", TBL[i].req), TBL[i].esel,
                             TBL[i].estall, TBL[i].eflush);
        end

        // Load walking EX -> MEM -> WB under a waiting BEQ r1,r2 (R7).
        @(negedge clk);
        apply('{4'd7, 1'b0, 2'd1, 5'd1, 5'd2, 8'h40, 8'h40, 2'd2, 5'd1,
                2'd0, 5'd0, 8'h00, 16'h0010, 2'd0, 1'b1, 1'b0});
        #2 check_outputs("R7", 2'd0, 1'b1, 1'b0);
        @(negedge clk);
        ex_wr_en = 1'b0; mem_wr_en = 1'b1; mem_is_load = 1'b1; mem_rd = 5'd1;
        #2 check_outputs("R7", 2'd0, 1'b1, 1'b0);
        @(negedge clk);
        mem_wr_en = 1'b0; mem_is_load = 1'b0;
        #2 check_outputs("R7", 2'd1, 1'b0, 1'b1);

        // ALU producer leaves EX, then is forwarded from MEM (R6, R8).
        @(negedge clk);
        apply('{4'd6, 1'b1, 2'd2, 5'd2, 5'd3, 8'h01, 8'h01, 2'd1, 5'd3,
                2'd0, 5'd0, 8'h00, 16'h0002, 2'd0, 1'b1, 1'b0});
        #2 check_outputs("R6", 2'd0, 1'b1, 1'b0);
        @(negedge clk);
        ex_wr_en = 1'b0; mem_wr_en = 1'b1; mem_rd = 5'd3; mem_result = 32'h0000_0099;
        #2 check_outputs("R8", 2'd1, 1'b0, 1'b0);

        // Jump with predict-not-taken flushes even with a load in MEM (R3, R5).
        @(negedge clk);
        apply('{4'd5, 1'b0, 2'd3, 5'd1, 5'd1, 8'h00, 8'h00, 2'd0, 5'd0,
                2'd2, 5'd1, 8'h00, 16'h0000, 2'd2, 1'b0, 1'b1});
        #2 check_outputs("R5", 2'd2, 1'b0, 1'b1);

        @(negedge clk);
        apply('0);
        #2 check_outputs("R10", 2'd0, 1'b0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule